// File: doc/BRIEF.md
# Sub-word Video Multiply-Add Unit

This unit performs one integer multiply-accumulate per accepted input. Each of the two multiplicands is cut from its source word before the multiply. A width code and a two-bit lane selector choose an 8-bit lane, a 16-bit lane or the whole 32-bit word. The chosen lane is then widened to 32 bits by sign or zero extension. A third 32-bit word is added to the product, and the low 32 bits of the sum are returned.

The second multiplicand comes either from a register word or from a 16-bit immediate. An immediate is always read as the low halfword, whatever width and lane codes come with it. Several modifier controls are not implemented: scale, operand negation, saturation and condition-code update. Any nonzero modifier raises an unsupported flag beside the result, and the arithmetic is still done as a plain multiply-add.

Timing is controlled by a two-state machine. In `ST_IDLE` no result is presented. In `ST_EMIT` a result registered on the previous edge is presented with `out_valid`. The transition to `ST_EMIT` is taken on any cycle with `in_valid` high, and the return to `ST_IDLE` on any cycle with `in_valid` low. A busy stream therefore stays in `ST_EMIT` cycle after cycle.

Top module: `vmac_unit`

## Requirements
- R1: Width code 0 and width code 1 both select the 8-bit lane that starts at bit lane×8 of the operand word.
- R2: Width code 2 selects the 16-bit lane that starts at bit lane×16. Lane codes 2 and 3 point past the word and give a zero multiplicand.
- R3: Width code 3 uses the full 32-bit word, and the lane code is then ignored.
- R4: Each multiplicand's extracted lane is sign-extended when its own sign input is 1 and zero-extended when it is 0.
- R5: When `b_is_reg` is 0, operand B is `imm_b` read as halfword lane 0. `src_b`, `b_width` and `b_lane` have no effect on the result.
- R6: `result` equals the low 32 bits of (extended A × extended B) + `src_c`, with `src_c` always used as a whole word.
- R7: `unsupported` is 1 with a result exactly when `scale` is nonzero or any of `neg_a`, `neg_c`, `sat`, `cc_en` is 1. The result is still A×B+C.
- R8: `out_valid` is high in exactly the cycle after each `in_valid` cycle and low otherwise. While `in_valid` is low, `result` and `unsupported` hold their values.
- R9: Synchronous active-high `rst` clears `out_valid`, `result` and `unsupported` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| src_a | input | 32 | Operand A word |
| src_b | input | 32 | Operand B register word |
| src_c | input | 32 | Addend word |
| imm_b | input | 16 | Immediate for operand B |
| b_is_reg | input | 1 | 1: B from `src_b`; 0: B from `imm_b` |
| a_width | input | 2 | A lane width code (0/1 byte, 2 half, 3 word) |
| a_lane | input | 2 | A lane selector |
| b_width | input | 2 | B lane width code |
| b_lane | input | 2 | B lane selector |
| a_signed | input | 1 | Sign-extend A lane |
| b_signed | input | 1 | Sign-extend B lane |
| scale | input | 2 | Scale modifier (unsupported if nonzero) |
| neg_a | input | 1 | Negate-A modifier (unsupported) |
| neg_c | input | 1 | Negate-C modifier (unsupported) |
| sat | input | 1 | Saturate modifier (unsupported) |
| cc_en | input | 1 | Condition-code modifier (unsupported) |
| out_valid | output | 1 | Result is present |
| result | output | 32 | Low 32 bits of A×B+C |
| unsupported | output | 1 | A modifier control was set for this result |

## Verification
A wrong state in the output machine shows at the ports within one cycle. Such a fault gives a missing strobe, a duplicated strobe, or a strobe one cycle late, which the scoreboard catches by the cycle each item is due. A wrong lane or extension choice only shows when the picked lane differs from its neighbours or has its top bit set. For that reason, operands use distinct byte values and lanes with the high bit set, and each fault appears as a wrong sum on the very next result. A result register that drifts while idle, or that survives reset, is caught within a few cycles by the idle and reset checks.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    typedef enum logic [1:0] {
        LW_BYTE     = 2'd0,
        LW_BYTE_ALT = 2'd1,
        LW_HALF     = 2'd2,
        LW_WORD     = 2'd3
    } lane_width_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pipe_state_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
endpackage

// File: rtl/vmac_lane_pick.sv
module vmac_lane_pick
    import vmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  lane_width_e       width,
    input  logic [1:0]        sel,
    input  logic              sgn,
    output logic [DATA_W-1:0] lane_ext
);
    logic [BYTE_W-1:0] byte_lane;
    logic [HALF_W-1:0] half_lane;

    always_comb begin
        byte_lane = word[BYTE_W*sel +: BYTE_W];
        half_lane = sel[1] ? '0 : word[HALF_W*sel[0] +: HALF_W];
        unique case (width)
            LW_BYTE, LW_BYTE_ALT:
                lane_ext = {{(DATA_W-BYTE_W){sgn & byte_lane[BYTE_W-1]}}, byte_lane};
            LW_HALF:
                lane_ext = {{(DATA_W-HALF_W){sgn & half_lane[HALF_W-1]}}, half_lane};
            LW_WORD:
                lane_ext = word;
        endcase
    end
endmodule

// File: rtl/vmac_ctrl_decode.sv
module vmac_ctrl_decode #(
    parameter int SCALE_W = 2
) (
    input  logic [SCALE_W-1:0] scale,
    input  logic               neg_a,
    input  logic               neg_c,
    input  logic               sat,
    input  logic               cc_en,
    output logic               unsup
);
    always_comb unsup = (|scale) | neg_a | neg_c | sat | cc_en;
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
    import vmac_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [DATA_W-1:0]  src_c,
    input  logic [IMM_W-1:0]   imm_b,
    input  logic               b_is_reg,
    input  logic [1:0]         a_width,
    input  logic [1:0]         a_lane,
    input  logic [1:0]         b_width,
    input  logic [1:0]         b_lane,
    input  logic               a_signed,
    input  logic               b_signed,
    input  logic [SCALE_W-1:0] scale,
    input  logic               neg_a,
    input  logic               neg_c,
    input  logic               sat,
    input  logic               cc_en,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               unsupported
);
    localparam int N_OPS = 2;

    logic [DATA_W-1:0] op_word [N_OPS];
    lane_width_e       op_wid  [N_OPS];
    logic [1:0]        op_sel  [N_OPS];
    logic              op_sgn  [N_OPS];
    logic [DATA_W-1:0] op_ext  [N_OPS];

    // Operand B source: immediate forces halfword lane 0
    always_comb begin
        op_word[0] = src_a;
        op_wid[0]  = lane_width_e'(a_width);
        op_sel[0]  = a_lane;
        op_sgn[0]  = a_signed;
        op_word[1] = b_is_reg ? src_b : {{(DATA_W-IMM_W){1'b0}}, imm_b};
        op_wid[1]  = b_is_reg ? lane_width_e'(b_width) : LW_HALF;
        op_sel[1]  = b_is_reg ? b_lane : 2'd0;
        op_sgn[1]  = b_signed;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        vmac_lane_pick #(.DATA_W(DATA_W)) i_pick (
            .word     (op_word[g]),
            .width    (op_wid[g]),
            .sel      (op_sel[g]),
            .sgn      (op_sgn[g]),
            .lane_ext (op_ext[g])
        );
    end

    logic unsup_now;
    vmac_ctrl_decode #(.SCALE_W(SCALE_W)) i_ctrl (
        .scale (scale),
        .neg_a (neg_a),
        .neg_c (neg_c),
        .sat   (sat),
        .cc_en (cc_en),
        .unsup (unsup_now)
    );

    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] sum;
    always_comb begin
        prod = op_ext[0] * op_ext[1];
        sum  = prod + src_c;
    end

    pipe_state_e st, st_nx;

    always_comb begin
        unique case (st)
            ST_IDLE: st_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_nx = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result      <= '0;
            unsupported <= 1'b0;
        end else if (in_valid) begin
            result      <= sum;
            unsupported <= unsup_now;
        end
    end

    always_comb begin
        unique case (st)
            ST_IDLE: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
        endcase
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(unsupported)));
    // R7
    unsup_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (scale != '0 || neg_a || neg_c || sat || cc_en)) |=> unsupported);
    // R7
    sup_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scale == '0 && !neg_a && !neg_c && !sat && !cc_en) |=> !unsupported);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !unsupported));
endmodule

// File: tb/test_vmac_unit.sv
module test_vmac_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, src_c = '0;
    logic [15:0] imm_b = '0;
    logic b_is_reg = 1'b1;
    logic [1:0] a_width = '0, a_lane = '0, b_width = '0, b_lane = '0;
    logic a_signed = 1'b0, b_signed = 1'b0;
    logic [1:0] scale = '0;
    logic neg_a = 1'b0, neg_c = 1'b0, sat = 1'b0, cc_en = 1'b0;
    logic out_valid, unsupported;
    logic [31:0] result;

    always #10 clk = ~clk;

    vmac_unit i_vmac_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm_b(imm_b),
        .b_is_reg(b_is_reg), .a_width(a_width), .a_lane(a_lane),
        .b_width(b_width), .b_lane(b_lane), .a_signed(a_signed),
        .b_signed(b_signed), .scale(scale), .neg_a(neg_a), .neg_c(neg_c),
        .sat(sat), .cc_en(cc_en), .out_valid(out_valid), .result(result),
        .unsupported(unsupported)
    );

    typedef struct {
        logic [31:0] r;
        bit          u;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] last_r;
    bit last_u;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input logic [31:0] w, input int wd, input int sel, input bit s);
        logic [31:0] v;
        if (wd <= 1) begin
            v = (w >> (8*sel)) & 32'hFF;
            if (s && v[7]) v = v | 32'hFFFF_FF00;
        end else if (wd == 2) begin
            v = (sel >= 2) ? 32'h0 : ((w >> (16*sel)) & 32'hFFFF);
            if (s && v[15]) v = v | 32'hFFFF_0000;
        end else begin
            v = w;
        end
        return v;
    endfunction

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                        input logic [15:0] imm, input bit breg,
                        input int aw, input int asel, input int bw, input int bsel,
                        input bit as, input bit bs, input logic [1:0] sc,
                        input bit na, input bit nc, input bit st, input bit cc,
                        input string tag);
        exp_t e;
        logic [31:0] bw_word;
        @(negedge clk);
        src_a = a; src_b = b; src_c = c; imm_b = imm; b_is_reg = breg;
        a_width = 2'(aw); a_lane = 2'(asel); b_width = 2'(bw); b_lane = 2'(bsel);
        a_signed = as; b_signed = bs; scale = sc;
        neg_a = na; neg_c = nc; sat = st; cc_en = cc;
        in_valid = 1'b1;
        bw_word = breg ? pick(b, bw, bsel, bs) : pick({16'h0, imm}, 2, 0, bs);
        e.r = pick(a, aw, asel, as) * bw_word + c;
        e.u = (sc != 2'b00) || na || nc || st || cc;
        e.due = cyc + 1;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        src_a = 32'hDEAD_BEEF; src_c = 32'h1234_5678;
        scale = 2'b11;
        repeat (n) @(negedge clk);
        scale = 2'b00;
    endtask

    // Monitor: pops expected items as results appear
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.due == cyc, {e.tag, " R8 timing"}, 32'(cyc), 32'(e.due));
                    check(result == e.r, {e.tag, " result"}, result, e.r);
                    check(unsupported == e.u, {e.tag, " R7 flag"}, 32'(unsupported), 32'(e.u));
                    last_r = e.r;
                    last_u = e.u;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && result == 32'h0 && !unsupported, "R9 reset state", result, 32'h0);
        rst = 1'b0;

        // R3 R6: full words, lane codes ignored
        send(32'd7, 32'd6, 32'd100, 16'h0, 1, 3, 3, 3, 2, 0, 0, 2'b00, 0, 0, 0, 0, "R3 word");
        // R1: byte lanes, codes 0 and 1
        send(32'h1122_3344, 32'hAABB_CCDD, 32'd1, 16'h0, 1, 0, 2, 1, 1, 0, 0, 2'b00, 0, 0, 0, 0, "R1 byte");
        // R4: signed byte lane of B
        send(32'h1122_3344, 32'hAABB_CCDD, 32'd1, 16'h0, 1, 0, 2, 1, 1, 0, 1, 2'b00, 0, 0, 0, 0, "R4 sbyte");
        // R1 R4: byte lane 3 signed on A
        send(32'h9000_0000, 32'd3, 32'd0, 16'h0, 1, 1, 3, 3, 0, 1, 0, 2'b00, 0, 0, 0, 0, "R1 lane3");
        // R2 R4: halfword lane 1 signed
        send(32'h8000_1234, 32'd5, 32'd9, 16'h0, 1, 2, 1, 3, 0, 1, 0, 2'b00, 0, 0, 0, 0, "R2 half1");
        // R2: halfword lane 1 unsigned
        send(32'h8000_1234, 32'd5, 32'd9, 16'h0, 1, 2, 1, 3, 0, 0, 0, 2'b00, 0, 0, 0, 0, "R2 half1u");
        // R2: halfword lane code past the word gives zero
        send(32'hFFFF_FFFF, 32'd5, 32'd77, 16'h0, 1, 2, 2, 3, 0, 1, 0, 2'b00, 0, 0, 0, 0, "R2 half2");
        send(32'd4, 32'hFFFF_FFFF, 32'd78, 16'h0, 1, 3, 0, 2, 3, 0, 1, 2'b00, 0, 0, 0, 0, "R2 half3");
        // R5: immediate, B word/width/lane fields ignored
        send(32'd3, 32'h7777_7777, 32'd10, 16'hFFFE, 0, 3, 0, 0, 3, 0, 1, 2'b00, 0, 0, 0, 0, "R5 imm signed");
        send(32'd3, 32'h7777_7777, 32'd10, 16'hFFFE, 0, 3, 0, 3, 1, 0, 0, 2'b00, 0, 0, 0, 0, "R5 imm unsigned");
        // R6: wraparound
        send(32'hFFFF_FFFF, 32'd2, 32'd5, 16'h0, 1, 3, 0, 3, 0, 1, 1, 2'b00, 0, 0, 0, 0, "R6 wrap");
        send(32'h0001_0000, 32'h0001_0000, 32'hFFFF_FFFF, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 0, 0, 0, 0, "R6 overflow");
        idle(2);
        check(q.size() == 0, "R8 drained", 32'(q.size()), 32'd0);

        // R7: each modifier alone
        send(32'd2, 32'd3, 32'd4, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b01, 0, 0, 0, 0, "R7 scale");
        send(32'd2, 32'd3, 32'd5, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b10, 0, 0, 0, 0, "R7 scale2");
        send(32'd2, 32'd3, 32'd6, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 1, 0, 0, 0, "R7 nega");
        send(32'd2, 32'd3, 32'd7, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 0, 1, 0, 0, "R7 negc");
        send(32'd2, 32'd3, 32'd8, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R7 sat");
        send(32'd2, 32'd3, 32'd9, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 0, 0, 0, 1, "R7 cc");
        send(32'd2, 32'd3, 32'd10, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 0, 0, 0, 0, "R7 none");
        idle(1);

        // R8: back-to-back stream with mixed modes
        for (int i = 0; i < 8; i++) begin
            send(32'h0102_0304 * (i + 1), 32'hF0E1_D2C3 + i, 32'(i * 1000), 16'(16'h8001 + i),
                 i[0], i % 4, (i + 1) % 4, (i + 2) % 4, i % 4, i[1], i[2], 2'(i % 2), 0, 0, 0, 0, "R8 stream");
        end
        idle(4);
        check(!out_valid, "R8 idle no valid", 32'(out_valid), 32'd0);
        check(result == last_r && unsupported == last_u, "R8 hold", result, last_r);
        check(q.size() == 0, "R8 drained2", 32'(q.size()), 32'd0);

        // R9: reset clears a nonzero result with the flag set
        send(32'd11, 32'd13, 32'd1, 16'h0, 1, 3, 0, 3, 0, 0, 0, 2'b00, 0, 0, 1, 0, "R9 pre");
        idle(1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && result == 32'h0 && !unsupported, "R9 mid reset", result, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R9 after reset", 32'(out_valid), 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule